// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block walks the singly linked chain of extended capability headers that lives in the upper part of a 4 KB configuration space. It has no storage of its own for the space: it reaches each 32-bit header through a synchronous single-port memory, with one read in flight at a time. Each header names its capability with a 16-bit ID, carries a 4-bit version, and points to the next header with a 12-bit byte offset; a pointer of zero closes the chain. The chain always begins at byte offset 0x100.

Two operations exist. A lookup returns the byte offset of the first header whose ID equals the requested one, or 0 when there is none, and reports the offset of the header visited just before the result. An insertion links a new header onto the chain. It first walks to the last header, replaces only that header's pointer field with the new offset, then writes the new header with a zero pointer. An insertion at 0x100 itself writes the first header directly, without reading anything. Offsets outside the legal window, runaway walks and bad insertion arguments end the operation with an error flag.

Top module: `ecap_walker`

## Requirements
- R1: After synchronous reset, `busy`, `done`, all three error flags, `res_off` and `res_prev` are 0, and no memory read or write is issued until a request is accepted.
- R2: A header holds the ID in bits 15:0, the version in bits 19:16 and the next byte offset in bits 31:20. A lookup (`req_append`=0) returns in `res_off` the offset of the first header on the chain whose ID equals `req_id`, and in `res_prev` the offset of the header visited before it (0 when the match is at 0x100).
- R3: When the header at 0x100 is all zero, a lookup reports `res_off`=0 and `res_prev`=0 with no error.
- R4: A requested ID with any bit set above bit 15 matches no header. The walk runs to the end of the chain and reports `res_off`=0 with `res_prev` equal to the offset of the last header.
- R5: A lookup for an in-range ID that is not on the chain reports `res_off`=0 and `res_prev` equal to the offset of the last header.
- R6: When a pointer that must be followed is below 0x100 or above 0xFF8, the walk stops with `err_range`=1, `res_off`=0 and `res_prev` equal to the offset of the header holding that pointer; no read outside 0x100..0xFF8 is issued and nothing is written.
- R7: When the walk has followed MAX_STEPS pointers and must follow another, it stops with `err_loop`=1 and `res_off`=0.
- R8: An insertion (`req_append`=1) whose `req_off` is below 0x100, is not a multiple of 4, whose `req_size` is below 8, or whose `req_off`+`req_size` exceeds 0x1000 is refused with `err_arg`=1 and leaves memory untouched.
- R9: An insertion at exactly 0x100 writes {12'h000, `req_ver`, `req_id`[15:0]} to 0x100 without any read, and reports `res_off`=0x100, `res_prev`=0.
- R10: An insertion elsewhere finds the last header (the first whose pointer is 0, starting at 0x100 even when that header is all zero), rewrites only its bits 31:20 with `req_off`, then writes {12'h000, `req_ver`, `req_id`[15:0]} at `req_off`; `res_off`=`req_off`, `res_prev`=offset of that last header.
- R11: A request is taken only when idle. `busy` is high from the cycle after a walking request is accepted up to the result, `done` pulses for one cycle with the results and error flags, and `busy` and `done` are never high together; a request raised while busy has no effect.
- R12: The memory port never reads and writes in the same cycle, and every read address lies in the window 0x100..0xFF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_append | input | 1 | 0 = lookup, 1 = insertion |
| req_id | input | REQ_ID_W | Requested or new capability ID |
| req_ver | input | 4 | Version of the new header |
| req_off | input | OFF_W | Byte offset of the new header |
| req_size | input | OFF_W | Byte size of the new capability |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| res_off | output | OFF_W | Found or inserted offset, 0 if none |
| res_prev | output | OFF_W | Previously visited or last header offset |
| err_range | output | 1 | Pointer left the legal window |
| err_loop | output | 1 | Step limit reached |
| err_arg | output | 1 | Insertion arguments refused |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | WA_W | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_re` |

## Verification
The hardest situation to reach from the ports is the step limit: a well-formed chain ends long before 1024 pointers, so the bench plants a header at 0x100 whose pointer refers back to itself and lets the walk spin until the limit fires. Out-of-window pointers are likewise planted on purpose in the tail header, both below 0x100 and above 0xFF8. Random chains of up to six headers at scattered offsets, with repeated IDs, feed lookups for present, absent and over-wide IDs and insertions whose whole memory image is compared afterwards.

// File: rtl/ecap_walk_pkg.sv
package ecap_walk_pkg;

  localparam int ID_W  = 16;
  localparam int VER_W = 4;
  localparam int NXT_W = 12;

  typedef struct packed {
    logic [NXT_W-1:0] nxt;
    logic [VER_W-1:0] ver;
    logic [ID_W-1:0]  id;
  } ecap_hdr_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_EVAL,
    ST_WNEW
  } walk_state_t;

  typedef enum logic [2:0] {
    ACT_FOLLOW,
    ACT_EMPTY,
    ACT_FOUND,
    ACT_MISS,
    ACT_TAIL,
    ACT_RANGE,
    ACT_LOOP
  } walk_act_t;

endpackage

// File: rtl/ecap_hdr_eval.sv
// Decodes one fetched header against the current request.
module ecap_hdr_eval
  import ecap_walk_pkg::*;
#(
  parameter int CFG_BYTES = 4096,
  parameter int BASE_OFF  = 256,
  parameter int MIN_SIZE  = 8,
  parameter int REQ_ID_W  = 20,
  localparam int OFF_W    = $clog2(CFG_BYTES) + 1
) (
  input  logic [31:0]         hdr_raw,
  input  logic [OFF_W-1:0]    cur_off,
  input  logic [REQ_ID_W-1:0] want_id,
  input  logic                seek_tail,
  output logic                is_empty,
  output logic                is_match,
  output logic                is_tail,
  output logic                nxt_bad,
  output logic [OFF_W-1:0]    nxt_off
);
  localparam int HI_OFF = CFG_BYTES - MIN_SIZE;

  ecap_hdr_t       hdr;
  logic            id_fits;
  logic [ID_W-1:0] id_lo;

  assign hdr = ecap_hdr_t'(hdr_raw);

  // IDs wider than the header field can only match when the excess bits are clear.
  generate
    if (REQ_ID_W > ID_W) begin : g_wide_id
      assign id_fits = (want_id[REQ_ID_W-1:ID_W] == '0);
      assign id_lo   = want_id[ID_W-1:0];
    end else begin : g_exact_id
      assign id_fits = 1'b1;
      assign id_lo   = ID_W'(want_id);
    end
  endgenerate

  assign nxt_off  = OFF_W'(hdr.nxt);
  assign nxt_bad  = (nxt_off < OFF_W'(BASE_OFF)) || (nxt_off > OFF_W'(HI_OFF));
  assign is_tail  = (hdr.nxt == '0);
  // A tail search never treats the first header as an empty chain nor matches.
  assign is_empty = !seek_tail && (cur_off == OFF_W'(BASE_OFF)) && (hdr_raw == '0);
  assign is_match = !seek_tail && id_fits && (hdr.id == id_lo);

endmodule

// File: rtl/ecap_append_check.sv
// Validates insertion arguments.
module ecap_append_check #(
  parameter int CFG_BYTES = 4096,
  parameter int BASE_OFF  = 256,
  parameter int MIN_SIZE  = 8,
  localparam int OFF_W    = $clog2(CFG_BYTES) + 1
) (
  input  logic [OFF_W-1:0] new_off,
  input  logic [OFF_W-1:0] new_size,
  output logic             args_ok,
  output logic             at_base
);
  logic [OFF_W:0] span_end;

  assign span_end = {1'b0, new_off} + {1'b0, new_size};
  assign at_base  = (new_off == OFF_W'(BASE_OFF));
  assign args_ok  = (new_off >= OFF_W'(BASE_OFF))
                 && (new_off[1:0] == 2'b00)
                 && (new_size >= OFF_W'(MIN_SIZE))
                 && (span_end <= (OFF_W+1)'(CFG_BYTES));

endmodule

// File: rtl/ecap_step_cnt.sv
// Counts followed pointers and flags the limit.
module ecap_step_cnt #(
  parameter int MAX_STEPS = 1024,
  localparam int CW       = $clog2(MAX_STEPS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign at_limit = (cnt == CW'(MAX_STEPS));

endmodule

// File: rtl/ecap_walker.sv
// Extended capability chain walker: lookup and insertion over a sync RAM port.
// The 12-bit next field of the header fixes the space at 4 KB.
module ecap_walker
  import ecap_walk_pkg::*;
#(
  parameter int CFG_BYTES = 4096,
  parameter int BASE_OFF  = 256,
  parameter int MIN_SIZE  = 8,
  parameter int MAX_STEPS = 1024,
  parameter int REQ_ID_W  = 20,
  localparam int OFF_W    = $clog2(CFG_BYTES) + 1,
  localparam int WA_W     = $clog2(CFG_BYTES) - 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_append,
  input  logic [REQ_ID_W-1:0] req_id,
  input  logic [VER_W-1:0]    req_ver,
  input  logic [OFF_W-1:0]    req_off,
  input  logic [OFF_W-1:0]    req_size,
  output logic                busy,
  output logic                done,
  output logic [OFF_W-1:0]    res_off,
  output logic [OFF_W-1:0]    res_prev,
  output logic                err_range,
  output logic                err_loop,
  output logic                err_arg,
  output logic                mem_re,
  output logic                mem_we,
  output logic [WA_W-1:0]     mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic [31:0]         mem_rdata
);
  localparam logic [OFF_W-1:0] BASE = OFF_W'(BASE_OFF);
  localparam logic [WA_W-1:0]  BASE_WA = BASE[WA_W+1:2];

  walk_state_t          state;
  walk_act_t            act;
  logic                 seek_tail_q;
  logic [REQ_ID_W-1:0]  id_q;
  logic [VER_W-1:0]     ver_q;
  logic [OFF_W-1:0]     new_q;
  logic [OFF_W-1:0]     cur_q;
  logic [OFF_W-1:0]     prev_q;

  logic                 is_empty, is_match, is_tail, nxt_bad;
  logic [OFF_W-1:0]     nxt_off;
  logic                 args_ok, at_base;
  logic                 at_limit;
  logic                 accept;
  logic                 step_inc;
  logic [31:0]          req_hdr;
  logic [31:0]          held_hdr;

  ecap_hdr_eval #(
    .CFG_BYTES(CFG_BYTES), .BASE_OFF(BASE_OFF),
    .MIN_SIZE(MIN_SIZE), .REQ_ID_W(REQ_ID_W)
  ) u_eval (
    .hdr_raw  (mem_rdata),
    .cur_off  (cur_q),
    .want_id  (id_q),
    .seek_tail(seek_tail_q),
    .is_empty (is_empty),
    .is_match (is_match),
    .is_tail  (is_tail),
    .nxt_bad  (nxt_bad),
    .nxt_off  (nxt_off)
  );

  ecap_append_check #(
    .CFG_BYTES(CFG_BYTES), .BASE_OFF(BASE_OFF), .MIN_SIZE(MIN_SIZE)
  ) u_args (
    .new_off (req_off),
    .new_size(req_size),
    .args_ok (args_ok),
    .at_base (at_base)
  );

  ecap_step_cnt #(.MAX_STEPS(MAX_STEPS)) u_steps (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept),
    .inc     (step_inc),
    .at_limit(at_limit)
  );

  assign accept   = (state == ST_IDLE) && req_valid;
  assign step_inc = (state == ST_EVAL) && (act == ACT_FOLLOW);

  // New headers always close the chain.
  assign req_hdr  = {{NXT_W{1'b0}}, req_ver, req_id[ID_W-1:0]};
  assign held_hdr = {{NXT_W{1'b0}}, ver_q, id_q[ID_W-1:0]};

  // Priority of outcomes for one fetched header.
  always_comb begin
    if (is_empty)           act = ACT_EMPTY;
    else if (is_match)      act = ACT_FOUND;
    else if (is_tail)       act = seek_tail_q ? ACT_TAIL : ACT_MISS;
    else if (nxt_bad)       act = ACT_RANGE;
    else if (at_limit)      act = ACT_LOOP;
    else                    act = ACT_FOLLOW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      busy        <= 1'b0;
      done        <= 1'b0;
      res_off     <= '0;
      res_prev    <= '0;
      err_range   <= 1'b0;
      err_loop    <= 1'b0;
      err_arg     <= 1'b0;
      mem_re      <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      seek_tail_q <= 1'b0;
      id_q        <= '0;
      ver_q       <= '0;
      new_q       <= '0;
      cur_q       <= '0;
      prev_q      <= '0;
    end else begin
      done   <= 1'b0;
      mem_re <= 1'b0;
      mem_we <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            seek_tail_q <= req_append;
            id_q        <= req_id;
            ver_q       <= req_ver;
            new_q       <= req_off;
            cur_q       <= BASE;
            prev_q      <= '0;
            if (req_append && !args_ok) begin
              done      <= 1'b1;
              err_arg   <= 1'b1;
              err_range <= 1'b0;
              err_loop  <= 1'b0;
              res_off   <= '0;
              res_prev  <= '0;
            end else if (req_append && at_base) begin
              mem_we    <= 1'b1;
              mem_addr  <= BASE_WA;
              mem_wdata <= req_hdr;
              done      <= 1'b1;
              err_arg   <= 1'b0;
              err_range <= 1'b0;
              err_loop  <= 1'b0;
              res_off   <= BASE;
              res_prev  <= '0;
            end else begin
              mem_re   <= 1'b1;
              mem_addr <= BASE_WA;
              busy     <= 1'b1;
              state    <= ST_RD;
            end
          end
        end

        ST_RD: state <= ST_EVAL;

        ST_EVAL: begin
          unique case (act)
            ACT_FOLLOW: begin
              prev_q   <= cur_q;
              cur_q    <= nxt_off;
              mem_re   <= 1'b1;
              mem_addr <= nxt_off[WA_W+1:2];
              state    <= ST_RD;
            end
            ACT_TAIL: begin
              // Replace only the pointer field of the last header.
              mem_we    <= 1'b1;
              mem_addr  <= cur_q[WA_W+1:2];
              mem_wdata <= {new_q[NXT_W-1:0], mem_rdata[ID_W+VER_W-1:0]};
              res_prev  <= cur_q;
              state     <= ST_WNEW;
            end
            default: begin
              done      <= 1'b1;
              busy      <= 1'b0;
              state     <= ST_IDLE;
              err_arg   <= 1'b0;
              err_range <= (act == ACT_RANGE);
              err_loop  <= (act == ACT_LOOP);
              res_off   <= (act == ACT_FOUND) ? cur_q : '0;
              if (act == ACT_FOUND)      res_prev <= prev_q;
              else if (act == ACT_EMPTY) res_prev <= '0;
              else                       res_prev <= cur_q;
            end
          endcase
        end

        ST_WNEW: begin
          mem_we    <= 1'b1;
          mem_addr  <= new_q[WA_W+1:2];
          mem_wdata <= held_hdr;
          done      <= 1'b1;
          busy      <= 1'b0;
          err_arg   <= 1'b0;
          err_range <= 1'b0;
          err_loop  <= 1'b0;
          res_off   <= new_q;
          state     <= ST_IDLE;
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ecap_walker_chk.sv
// Property checker for ecap_walker, attached by bind.
module ecap_walker_chk #(
  parameter int CFG_BYTES = 4096,
  parameter int BASE_OFF  = 256,
  parameter int MIN_SIZE  = 8,
  parameter int MAX_STEPS = 1024,
  localparam int OFF_W    = $clog2(CFG_BYTES) + 1,
  localparam int WA_W     = $clog2(CFG_BYTES) - 2
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             err_range,
  input logic             err_loop,
  input logic             err_arg,
  input logic             mem_re,
  input logic             mem_we,
  input logic [WA_W-1:0]  mem_addr,
  input logic [OFF_W-1:0] res_off
);
  localparam int LO_WA = BASE_OFF / 4;
  localparam int HI_WA = (CFG_BYTES - MIN_SIZE) / 4;
  localparam int BUSY_MAX = 2 * MAX_STEPS + 8;

  logic [31:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_run <= '0;
    else              busy_run <= busy_run + 1;
  end

  a_r11_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)) else $error("busy and done overlap");

  a_r12_no_rw_overlap: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we)) else $error("read and write in one cycle");

  a_r12_read_window: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (mem_addr >= WA_W'(LO_WA)) && (mem_addr <= WA_W'(HI_WA)))
    else $error("read outside header window");

  a_r6_range_flag_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(err_range) |-> done) else $error("range flag without done");

  a_r7_loop_flag_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(err_loop) |-> done) else $error("loop flag without done");

  a_r8_arg_no_access: assert property (@(posedge clk) disable iff (rst)
    (done && err_arg) |-> (!mem_we && !mem_re)) else $error("access on refused insertion");

  a_r11_write_in_op: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (busy || done)) else $error("write outside an operation");

  a_r7_walk_bounded: assert property (@(posedge clk) disable iff (rst)
    busy_run < 32'(BUSY_MAX)) else $error("walk exceeds step bound");

  a_r2_result_in_window: assert property (@(posedge clk) disable iff (rst)
    (done && res_off != '0) |-> (res_off >= OFF_W'(BASE_OFF)))
    else $error("result offset below base");

endmodule

bind ecap_walker ecap_walker_chk #(
  .CFG_BYTES(CFG_BYTES), .BASE_OFF(BASE_OFF),
  .MIN_SIZE(MIN_SIZE), .MAX_STEPS(MAX_STEPS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .err_range(err_range),
  .err_loop (err_loop),
  .err_arg  (err_arg),
  .mem_re   (mem_re),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .res_off  (res_off)
);

// File: tb/ecap_walker_tb.sv
`timescale 1ns/1ps
module ecap_walker_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_append = 1'b0;
  logic [19:0] req_id = '0;
  logic [3:0]  req_ver = '0;
  logic [12:0] req_off = '0;
  logic [12:0] req_size = '0;
  logic        busy, done, err_range, err_loop, err_arg;
  logic [12:0] res_off, res_prev;
  logic        mem_re, mem_we;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  logic        tb_we = 1'b0;
  logic [9:0]  tb_waddr = '0;
  logic [31:0] tb_wdata = '0;

  logic [31:0] mem     [0:1023];
  logic [31:0] exp_mem [0:1023];

  int n_vec = 0, n_bad = 0;
  int rd_cnt = 0, overlap_cnt = 0, badrd_cnt = 0;
  int r_off, r_prev, r_er, r_el, r_ea;
  bit saw_busy, pulse_ok;

  always #5 clk = ~clk;

  ecap_walker u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_append(req_append),
    .req_id(req_id), .req_ver(req_ver), .req_off(req_off), .req_size(req_size),
    .busy(busy), .done(done), .res_off(res_off), .res_prev(res_prev),
    .err_range(err_range), .err_loop(err_loop), .err_arg(err_arg),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Synchronous single-port RAM with a bench loading path.
  always @(posedge clk) begin
    if (tb_we)       mem[tb_waddr] <= tb_wdata;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re)      mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (mem_re) rd_cnt++;
      if (mem_re && mem_we) overlap_cnt++;
      if (mem_re && (mem_addr < 10'd64 || mem_addr > 10'd1022)) badrd_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(input int byte_off, input logic [31:0] d);
    tb_we = 1'b1; tb_waddr = 10'(byte_off >> 2); tb_wdata = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) poke(i * 4, 32'h0);
  endtask

  function automatic logic [31:0] mk_hdr(input int nxt, input logic [3:0] v, input logic [15:0] id);
    return {12'(nxt), v, id};
  endfunction

  function automatic int count_diff();
    int d = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) d++;
    return d;
  endfunction

  // Expected lookup result from the requirement text.
  function automatic void ref_find(input logic [19:0] id, output int off, output int prev, output int err);
    int cur = 256, pv = 0, steps = 0, nx;
    logic [31:0] h;
    off = 0; prev = 0; err = 0;
    while (1) begin
      h = mem[cur >> 2];
      if (cur == 256 && h == 32'h0) return;
      if (id[19:16] == 4'h0 && h[15:0] == id[15:0]) begin off = cur; prev = pv; return; end
      nx = int'(h[31:20]);
      if (nx == 0) begin prev = cur; return; end
      if (nx < 256 || nx > 4088) begin prev = cur; err = 1; return; end
      if (steps == 1024) begin prev = cur; err = 2; return; end
      pv = cur; cur = nx; steps++;
    end
  endfunction

  function automatic int ref_tail();
    int cur = 256;
    for (int k = 0; k < 64; k++) begin
      if (mem[cur >> 2][31:20] == 12'h0) return cur;
      cur = int'(mem[cur >> 2][31:20]);
    end
    return cur;
  endfunction

  task automatic do_req(input bit app, input logic [19:0] id, input logic [3:0] ver,
                        input int off, input int size);
    bit got = 0;
    @(negedge clk);
    req_valid = 1'b1; req_append = app; req_id = id; req_ver = ver;
    req_off = 13'(off); req_size = 13'(size);
    @(negedge clk);
    req_valid = 1'b0;
    saw_busy = busy;
    for (int i = 0; i < 5000 && !got; i++) begin
      if (done) got = 1;
      else @(negedge clk);
    end
    if (!got) chk("R11 done timeout", 32'h0, 32'h1);
    r_off = int'(res_off); r_prev = int'(res_prev);
    r_er = int'(err_range); r_el = int'(err_loop); r_ea = int'(err_arg);
    @(negedge clk);
    pulse_ok = !done;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog: actual hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int eo, ep, ee, rb, tail, n, s, off, size, mode;
    int offs [0:7];
    logic [15:0] ids [0:7];
    logic [63:0] used;
    logic [19:0] sid;
    logic [3:0]  v;

    void'($urandom(32'd4242));
    @(negedge clk);
    clear_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 errors", {29'h0, err_range, err_loop, err_arg}, 0);
    chk("R1 results", {6'h0, res_off, res_prev}, 0);
    chk("R1 no access", 32'(rd_cnt), 0);

    // R3 empty chain
    do_req(1'b0, 20'h00001, 4'h0, 0, 0);
    chk("R3 off", 32'(r_off), 0);
    chk("R3 prev", 32'(r_prev), 0);
    chk("R3 err", 32'(r_er + r_el), 0);
    chk("R11 busy after accept", 32'(saw_busy), 1);
    chk("R11 done one cycle", 32'(pulse_ok), 1);

    // R9 insertion at base
    rb = rd_cnt;
    do_req(1'b1, 20'h00001, 4'h1, 256, 16);
    chk("R9 header", mem[64], 32'h00010001);
    chk("R9 no reads", 32'(rd_cnt - rb), 0);
    chk("R9 res", {6'h0, 13'(r_off), 13'(r_prev)}, {6'h0, 13'h100, 13'h0});

    // R10 insertion after the base header
    do_req(1'b1, 20'h00002, 4'h2, 'h200, 16);
    chk("R10 tail pointer", mem[64], 32'h20010001);
    chk("R10 new header", mem[128], 32'h00020002);
    chk("R10 res_prev", 32'(r_prev), 'h100);
    chk("R10 res_off", 32'(r_off), 'h200);

    // R2 lookups
    do_req(1'b0, 20'h00002, 4'h0, 0, 0);
    chk("R2 off second", 32'(r_off), 'h200);
    chk("R2 prev second", 32'(r_prev), 'h100);
    do_req(1'b0, 20'h00001, 4'h0, 0, 0);
    chk("R2 off first", 32'(r_off), 'h100);
    chk("R2 prev first", 32'(r_prev), 0);

    // R4 over-wide ID, R5 absent ID
    do_req(1'b0, 20'h10002, 4'h0, 0, 0);
    chk("R4 off", 32'(r_off), 0);
    chk("R4 prev tail", 32'(r_prev), 'h200);
    do_req(1'b0, 20'h00009, 4'h0, 0, 0);
    chk("R5 off", 32'(r_off), 0);
    chk("R5 prev tail", 32'(r_prev), 'h200);

    // R8 refused insertions
    exp_mem = mem;
    do_req(1'b1, 20'h7, 4'h1, 'h0FC, 16);
    chk("R8 low offset", 32'(r_ea), 1);
    do_req(1'b1, 20'h7, 4'h1, 'h202, 16);
    chk("R8 misaligned", 32'(r_ea), 1);
    do_req(1'b1, 20'h7, 4'h1, 'h300, 4);
    chk("R8 small size", 32'(r_ea), 1);
    do_req(1'b1, 20'h7, 4'h1, 'hFF8, 16);
    chk("R8 past end", 32'(r_ea), 1);
    do_req(1'b1, 20'h7, 4'h1, 'hFF8, 8);
    chk("R8 exact fit accepted", 32'(r_ea), 0);
    exp_mem[128] = 32'hFF820002;
    exp_mem[1022] = 32'h00010007;
    @(negedge clk);
    chk("R8 memory untouched by refusals", 32'(count_diff()), 0);

    // R6 pointer out of window, below and above
    poke('h200, mk_hdr('h0FC, 4'h2, 16'h0002));
    do_req(1'b0, 20'h00009, 4'h0, 0, 0);
    chk("R6 low err", 32'(r_er), 1);
    chk("R6 low off", 32'(r_off), 0);
    chk("R6 low prev", 32'(r_prev), 'h200);
    poke('h200, mk_hdr('hFFC, 4'h2, 16'h0002));
    exp_mem = mem;
    do_req(1'b1, 20'h00009, 4'h1, 'h400, 8);
    chk("R6 high err", 32'(r_er), 1);
    @(negedge clk);
    chk("R6 no write", 32'(count_diff()), 0);

    // R7 self-referencing header
    poke('h100, mk_hdr('h100, 4'h1, 16'h0005));
    do_req(1'b0, 20'h00007, 4'h0, 0, 0);
    chk("R7 loop err", 32'(r_el), 1);
    chk("R7 off", 32'(r_off), 0);

    // R11 request raised while busy is ignored
    poke('h100, mk_hdr('h200, 4'h1, 16'h0001));
    poke('h200, mk_hdr(0, 4'h2, 16'h0002));
    @(negedge clk);
    req_valid = 1'b1; req_append = 1'b0; req_id = 20'h9; req_off = '0; req_size = '0;
    @(negedge clk);
    req_append = 1'b1; req_id = 20'hAAAA; req_ver = 4'h3; req_off = 13'h100; req_size = 13'd16;
    for (int i = 0; i < 100 && !done; i++) @(negedge clk);
    req_valid = 1'b0;
    r_off = int'(res_off); r_prev = int'(res_prev);
    repeat (3) @(negedge clk);
    chk("R11 ignored base header", mem[64], 32'h20010001);
    chk("R11 first result kept", {6'h0, 13'(r_off), 13'(r_prev)}, {6'h0, 13'h0, 13'h200});
    chk("R11 idle after", 32'(busy), 0);

    // R10 insertion on an all-zero first header
    clear_mem();
    do_req(1'b1, 20'h00033, 4'h4, 'h300, 8);
    chk("R10 zero base pointer", mem[64], 32'h30000000);
    chk("R10 zero base new", mem['h300 >> 2], 32'h00040033);
    chk("R10 zero base prev", 32'(r_prev), 'h100);

    // Random chains
    for (int it = 0; it < 24; it++) begin
      clear_mem();
      n = 1 + int'($urandom % 6);
      used = '0; used[0] = 1'b1; offs[0] = 256;
      for (int i = 1; i < n; i++) begin
        do s = 1 + int'($urandom % 59); while (used[s]);
        used[s] = 1'b1; offs[i] = 256 + 64 * s;
      end
      for (int i = 0; i < n; i++) begin
        ids[i] = (i > 0 && ($urandom % 4) == 0) ? ids[i-1] : 16'($urandom);
        poke(offs[i], mk_hdr((i < n - 1) ? offs[i+1] : 0, 4'($urandom), ids[i]));
      end
      mode = int'($urandom % 3);
      if (mode == 0)      sid = {4'h0, ids[$urandom % n]};
      else if (mode == 1) sid = {4'h0, 16'($urandom)};
      else                sid = {4'(1 + $urandom % 15), 16'($urandom)};
      ref_find(sid, eo, ep, ee);
      do_req(1'b0, sid, 4'h0, 0, 0);
      chk($sformatf("R2 R4 R5 random off it%0d", it), 32'(r_off), 32'(eo));
      chk($sformatf("R2 R4 R5 random prev it%0d", it), 32'(r_prev), 32'(ep));

      do s = 1 + int'($urandom % 59); while (used[s]);
      off = 256 + 64 * s;
      size = 8 + 8 * int'($urandom % 8);
      v = 4'($urandom);
      sid = {4'h0, 16'($urandom)};
      exp_mem = mem;
      tail = ref_tail();
      exp_mem[tail >> 2] = {12'(off), exp_mem[tail >> 2][19:0]};
      exp_mem[off >> 2] = {12'h0, v, sid[15:0]};
      do_req(1'b1, sid, v, off, size);
      chk($sformatf("R10 random mem it%0d", it), 32'(count_diff()), 0);
      chk($sformatf("R10 random prev it%0d", it), 32'(r_prev), 32'(tail));
    end

    chk("R12 no read-write overlap", 32'(overlap_cnt), 0);
    chk("R12 reads in window", 32'(badrd_cnt), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule